// File: doc/BRIEF.md
# Sound Port Wait-State Generator

This block sits between a CPU bus and a slow sound generator. The sound generator cannot take data at CPU speed. When the CPU writes a byte to the sound port, the block passes the byte on with a one-cycle strobe. It then holds the CPU ready line low for a fixed number of sound-chip clock periods.

The sound-chip clock is not a CPU clock. It is the video chip's crystal frequency divided by a constant, six by default. The block receives one enable pulse per crystal period, sampled in its own clock domain. A free-running divider, started at reset, turns every DIV-th crystal enable into one sound tick. The wait is measured in these ticks and never in CPU cycles. It ends on the exact edge of the last tick. With the defaults (32 ticks, divide by 6, a crystal near 21 MHz), a 3 MHz CPU sees about 27 wait states per sound write.

A state machine with three states drives the hold:
- `S_IDLE`: ready is high and writes are accepted.
- `S_ARM`: a write has been taken, and the machine waits for the next sound tick to line up the count.
- `S_HOLD`: the machine counts ticks.

The machine has four transitions:
- T_START: `S_IDLE` to `S_ARM` on an accepted write.
- T_SYNC: `S_ARM` to `S_HOLD` on the first tick.
- T_COUNT: `S_HOLD` stays in `S_HOLD` on each tick before the last.
- T_RELEASE: `S_HOLD` to `S_IDLE` on the last tick.

Top module: `snd_wait_gen`

## Requirements
- R1: After reset, `cpu_ready` is 1, `snd_we` is 0 and `snd_data` is 0.
- R2: A cycle with `cpu_wr_b`=1, `cpu_addr`=SND_ADDR (default 16'hF120) and `cpu_ready`=1 is accepted. On the next cycle `snd_we` is 1 for exactly one cycle, `snd_data` holds the written byte, and `cpu_ready` is 0.
- R3: A sound tick occurs on every DIV-th cycle with `xtal_en`=1, counted from the release of reset. The divider runs freely and is never restarted by a write.
- R4: The hold count starts at the first sound tick after the edge that accepted the write. Edges without a tick leave the machine in `S_ARM`.
- R5: `cpu_ready` returns to 1 on the edge of the WAIT_TICKS-th tick after the starting tick (default 32). The ready-low window therefore spans exactly WAIT_TICKS+1 tick edges and never extends past the last one.
- R6: A sound-port write presented while `cpu_ready` is 0 is ignored. It produces no strobe, leaves `snd_data` unchanged and does not lengthen the wait.
- R7: A write to any other address, or a cycle with `cpu_wr_b`=0, never lowers `cpu_ready` and never raises `snd_we`.
- R8: A sound-port write presented in the first cycle in which `cpu_ready` is 1 again is accepted, so back-to-back writes lose no cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_en | input | 1 | One pulse per video-crystal period |
| cpu_addr | input | ADDR_W (16) | CPU address bus |
| cpu_data | input | DATA_W (8) | CPU write data byte |
| cpu_wr_b | input | 1 | Byte-write strobe, one cycle per write |
| cpu_ready | output | 1 | CPU ready; 0 stalls the CPU |
| snd_we | output | 1 | One-cycle write strobe toward the sound generator |
| snd_data | output | DATA_W (8) | Byte latched for the sound generator |

## Verification
The bench builds the block with DIV=3 and WAIT_TICKS=5. This keeps each window short enough to run many of them, and it makes the release tick land on a divider boundary in every window. Crystal enables are driven first on every cycle and then in a sparse pseudo-random pattern. The sparse pattern makes the time spent in `S_ARM` vary, and it checks that the tick count, not the cycle count, sets the window length. A second write placed inside a window checks the ignore rule, and a write issued at the first ready cycle checks back-to-back acceptance.

// File: rtl/snd_wait_pkg.sv
package snd_wait_pkg;

    // Hold sequencer states
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARM  = 2'd1,
        S_HOLD = 2'd2
    } hold_state_e;

endpackage

// File: rtl/snd_clk_div.sv
module snd_clk_div #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_pass
            // Every crystal enable is a sound tick
            assign tick = xtal_en;
        end else begin : g_count
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] phase_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (xtal_en) begin
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
                end
            end

            assign tick = xtal_en && (phase_q == LAST);

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R3
        end
    endgenerate

endmodule

// File: rtl/snd_port_decode.sv
module snd_port_decode #(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SND_ADDR = 16'hF120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr_b,
    input  logic              accept,
    output logic              req,
    output logic              snd_we,
    output logic [DATA_W-1:0] snd_data
);
    // Byte write aimed at the sound port
    assign req = cpu_wr_b && (cpu_addr == SND_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snd_we   <= 1'b0;
            snd_data <= '0;
        end else begin
            snd_we <= accept;
            if (accept) begin
                snd_data <= cpu_data;
            end
        end
    end

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(snd_data)); // R6

endmodule

// File: rtl/snd_hold_fsm.sv
module snd_hold_fsm
    import snd_wait_pkg::*;
#(
    parameter int WAIT_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic tick,
    output logic ready,
    output logic accept
);
    localparam int HW = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;
    localparam logic [HW-1:0] LAST = HW'(WAIT_TICKS - 1);

    hold_state_e   state_q, state_d;
    logic [HW-1:0] cnt_q, cnt_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (req) begin
                    state_d = S_ARM;          // T_START
                end
            end
            S_ARM: begin
                if (tick) begin
                    state_d = S_HOLD;         // T_SYNC
                    cnt_d   = '0;
                end
            end
            S_HOLD: begin
                if (tick) begin
                    if (cnt_q == LAST) begin
                        state_d = S_IDLE;     // T_RELEASE
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1; // T_COUNT
                    end
                end
            end
            default: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        ready  = (state_q == S_IDLE);
        accept = (state_q == S_IDLE) && req;
    end

    AST_ARM_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARM && !tick) |=> (state_q == S_ARM)); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= LAST)); // R5
    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(tick)); // R5
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !accept); // R6

endmodule

// File: rtl/snd_wait_gen.sv
module snd_wait_gen #(
    parameter int              ADDR_W     = 16,
    parameter int              DATA_W     = 8,
    parameter logic [ADDR_W-1:0] SND_ADDR   = 16'hF120,
    parameter int              DIV        = 6,
    parameter int              WAIT_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr_b,
    output logic              cpu_ready,
    output logic              snd_we,
    output logic [DATA_W-1:0] snd_data
);
    logic snd_tick;
    logic port_req;
    logic port_accept;

    snd_clk_div #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .xtal_en (xtal_en),
        .tick    (snd_tick)
    );

    snd_port_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SND_ADDR (SND_ADDR)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr_b (cpu_wr_b),
        .accept   (port_accept),
        .req      (port_req),
        .snd_we   (snd_we),
        .snd_data (snd_data)
    );

    snd_hold_fsm #(.WAIT_TICKS(WAIT_TICKS)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (port_req),
        .tick   (snd_tick),
        .ready  (cpu_ready),
        .accept (port_accept)
    );

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        snd_we |=> !snd_we); // R2
    AST_STROBE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        snd_we |-> !cpu_ready); // R2
    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !(cpu_wr_b && cpu_addr == SND_ADDR)) |=> (cpu_ready && !snd_we)); // R7

endmodule

// File: tb/snd_wait_gen_tb.sv
module snd_wait_gen_tb;
    localparam int DIV   = 3;
    localparam int WAITT = 5;
    localparam logic [15:0] SADDR = 16'hF120;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0] cpu_data = '0;
    logic       cpu_wr_b = 1'b0;
    logic       cpu_ready;
    logic       snd_we;
    logic [7:0] snd_data;

    int tests = 0;
    int fails = 0;
    int xmode = 0;
    logic [7:0] lfsr = 8'h5B;
    logic [7:0] exp_q[$];
    logic done = 1'b0;

    always #10 clk = ~clk;

    snd_wait_gen #(.DIV(DIV), .WAIT_TICKS(WAITT)) u_dut (
        .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr_b(cpu_wr_b),
        .cpu_ready(cpu_ready), .snd_we(snd_we), .snd_data(snd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Crystal enable driver
    always @(negedge clk) begin
        #1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        xtal_en <= (xmode == 0) ? 1'b1 : lfsr[0];
    end

    // Monitor and scoreboard
    int xcnt = 0;
    int low_ticks = 0;
    logic prev_ready = 1'b1;
    initial begin
        forever begin
            @(negedge clk);
            begin
                bit etick;
                etick = 1'b0;
                if (!rst_n) begin
                    xcnt = 0;
                end else begin
                    etick = xtal_en && ((xcnt % DIV) == DIV - 1);
                    if (xtal_en) xcnt++;
                    if (!prev_ready && etick) low_ticks++;
                    if (prev_ready && !cpu_ready) begin
                        check(snd_we === 1'b1, "R7 ready fell without strobe", snd_we, 1);
                        low_ticks = 0;
                    end
                    if (snd_we) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R6 unexpected strobe", snd_data, 0);
                        end else begin
                            logic [7:0] e;
                            e = exp_q.pop_front();
                            check(snd_data == e, "R2 strobe data", snd_data, e);
                        end
                    end
                    if (!prev_ready && cpu_ready) begin
                        check(etick, "R3 release on sound tick", etick, 1);
                        check(low_ticks == WAITT + 1, "R4/R5 ticks in low window", low_ticks, WAITT + 1);
                    end
                end
                prev_ready = cpu_ready;
            end
        end
    end

    task automatic drive_wr(input logic [15:0] a, input logic [7:0] d, input logic wr);
        @(negedge clk); #1;
        cpu_addr = a; cpu_data = d; cpu_wr_b = wr;
        @(negedge clk); #1;
        cpu_wr_b = 1'b0;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
    endtask

    task automatic snd_write(input logic [7:0] d);
        exp_q.push_back(d);
        drive_wr(SADDR, d, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(cpu_ready === 1'b1, "R1 ready after reset", cpu_ready, 1);
        check(snd_we === 1'b0, "R1 strobe after reset", snd_we, 0);
        check(snd_data === 8'h00, "R1 data after reset", snd_data, 0);
        #1 rst_n = 1'b1;

        // R2: basic write with dense crystal enables
        wait_ready();
        snd_write(8'h9F);
        check(cpu_ready === 1'b0, "R2 ready low after accept", cpu_ready, 0);
        wait_ready();

        // R7: foreign address and missing strobe
        drive_wr(16'hF121, 8'h11, 1'b1);
        check(cpu_ready === 1'b1, "R7 other address", cpu_ready, 1);
        drive_wr(16'hF020, 8'h22, 1'b1);
        check(cpu_ready === 1'b1, "R7 other address 2", cpu_ready, 1);
        drive_wr(SADDR, 8'h33, 1'b0);
        repeat (2) @(negedge clk);
        check(cpu_ready === 1'b1 && snd_data == 8'h9F, "R7 no write strobe", snd_data, 8'h9F);

        // R6: write during busy window is dropped
        wait_ready();
        snd_write(8'hA5);
        drive_wr(SADDR, 8'h3C, 1'b1);
        repeat (2) @(negedge clk);
        check(snd_data == 8'hA5, "R6 data unchanged", snd_data, 8'hA5);
        wait_ready();

        // R8: back-to-back acceptance
        snd_write(8'h5A);
        while (!cpu_ready) @(negedge clk);
        #1; exp_q.push_back(8'hC3);
        cpu_addr = SADDR; cpu_data = 8'hC3; cpu_wr_b = 1'b1;
        @(negedge clk);
        check(snd_we === 1'b1 && cpu_ready === 1'b0, "R8 accepted at first ready cycle", snd_we, 1);
        #1 cpu_wr_b = 1'b0;
        wait_ready();

        // R3/R4: sparse crystal enables
        xmode = 1;
        for (int i = 0; i < 8; i++) begin
            wait_ready();
            snd_write(8'(8'h40 + i * 7));
        end
        wait_ready();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all writes strobed", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule